// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master side of a half-duplex single-wire serial bus. Software drives it through seven byte-wide registers: a fixed revision word, a transmit byte, a receive byte, a control word, an interrupt flag word, a configuration word and a reset-status word. Setting the start bit in the control word runs one operation on the line. The other control bits choose the operation: a break pulse that resets the slave, sending the transmit byte, or receiving one byte from the slave. The line is open-drain. The block has a drive-low enable output and takes the resolved line level back as a separate input.

Line timing is set by parameters given in clock cycles. Each transmitted bit cell opens with a low pulse whose length carries the bit value. In receive mode the slave makes each low pulse. The controller waits for each falling edge and samples the line a fixed number of cycles later. When an operation ends, the controller sets a completion flag and clears the start bit. Reading the flag word clears every flag. A level interrupt is raised while the interrupt enable is set and any flag is pending.

Top module: `sw_bus_master`

## Requirements
- R1: After reset the control word (word 3) and the flag word (word 4) read 0, the revision word (word 0) reads the REV parameter, reset-status bit0 (word 6) reads 1, `drive_low` is 0 and `irq` is 0.
- R2: Writing the control word with bit5 (clock enable) and bit4 (start) set and bit2 = 0, bit1 = 0 sends the transmit byte (word 1) least significant bit first. Each bit cell lasts CELL_CYC cycles and opens with a low pulse of ONE_LOW cycles for a 1 or ZERO_LOW cycles for a 0. When the byte is done, flag bit2 is set and control bit4 reads 0.
- R3: Writing control with bit5, bit4 and bit1 set receives a byte. After each slave falling edge the line is sampled SAMPLE_CYC cycles later, and a high level gives a 1. Bits arrive least significant first. After the eighth bit, the byte is readable at word 2, flag bit1 is set and control bit4 clears.
- R4: In receive mode, if no falling edge arrives within RXWAIT_CYC cycles, flag bit0 is set instead of bit1 and control bit4 clears.
- R5: Writing control with bit5, bit4 and bit2 set drives the line low for BRK_LOW cycles and then releases it for BRK_REC cycles. Only after that is flag bit0 set, with control bits 4 and 2 both reading 0.
- R6: Reading the flag word returns the pending flags and clears all three of them.
- R7: `irq` is high exactly while control bit6 (interrupt enable) is set and any flag is pending.
- R8: While bit4 is set, a write to the control word changes only bit6.
- R9: A start write with bit5 = 0 starts nothing: bit4 reads 0 and the line stays released.
- R10: Writing 1 to configuration bit1 (word 5) soft-resets the block. Reset-status bit0 reads 0 for RST_CYC cycles and then 1. Control, flags and data words are cleared. Configuration bit0 is stored and read back, and bit1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_word | input | 3 | Register word index (byte offset / 4) |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_rd | input | 1 | Read strobe for one cycle; clears flags when word 4 is read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected word, combinational |
| drive_low | output | 1 | Open-drain pull-down enable for the bus line |
| line_in | input | 1 | Resolved bus line level |
| irq | output | 1 | Level interrupt |

## Verification
A wrong sequencer state shows at `drive_low` within the same bit cell: one low pulse that is too long or too short changes the decoded bit and the measured cell length. Receive errors show only at the end of the byte, as a wrong value in word 2 or the wrong completion flag. A stuck start bit or a lost flag shows on the first poll of the control or flag word after the operation should have finished. A missed soft-reset clear shows on the read that follows the RST_CYC window.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef enum logic [1:0] {OP_SEND, OP_RECV, OP_BREAK} op_e;

  localparam logic [2:0] W_REV  = 3'd0;
  localparam logic [2:0] W_TXD  = 3'd1;
  localparam logic [2:0] W_RXD  = 3'd2;
  localparam logic [2:0] W_CTRL = 3'd3;
  localparam logic [2:0] W_FLAG = 3'd4;
  localparam logic [2:0] W_CFG  = 3'd5;
  localparam logic [2:0] W_STAT = 3'd6;

  localparam int C_IE   = 6;
  localparam int C_CLK  = 5;
  localparam int C_GO   = 4;
  localparam int C_BRK  = 2;
  localparam int C_DIR  = 1;
  localparam int C_MODE = 0;

  function automatic int unsigned low_len(input logic b, input int unsigned one_lo,
                                          input int unsigned zero_lo);
    return b ? one_lo : zero_lo;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sw_regs.sv
module sw_regs
  import sw_pkg::*;
#(
  parameter logic [7:0]  REV     = 8'h21,
  parameter int unsigned RST_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_word,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       done_tx,
  input  logic       done_rx,
  input  logic       done_to,
  input  logic [7:0] rx_byte,
  output logic       start,
  output op_e        start_op,
  output logic       busy,
  output logic [7:0] tx_byte,
  output logic       soft_clr,
  output logic       irq
);

  localparam int RCW = $clog2(RST_CYC + 1);

  logic ie_q, ce_q, go_q, brk_q, dir_q, mode_q, idle_q;
  logic [7:0] txd_q, rxd_q;
  logic [2:0] flags_q;
  logic [RCW-1:0] rcnt_q;
  logic start_q;
  op_e  op_q;

  logic wr_ctrl, soft_req, soft_act, go_req, done_any, rd_flag;

  assign wr_ctrl  = reg_wr && (reg_word == W_CTRL);
  assign rd_flag  = reg_rd && (reg_word == W_FLAG);
  assign soft_req = reg_wr && (reg_word == W_CFG) && reg_wdata[1];
  assign soft_act = (rcnt_q != '0);
  assign soft_clr = soft_req || soft_act;
  assign go_req   = wr_ctrl && !go_q && reg_wdata[C_GO] && reg_wdata[C_CLK];
  assign done_any = done_tx || done_rx || done_to;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0; ce_q <= 1'b0; go_q <= 1'b0; brk_q <= 1'b0;
      dir_q <= 1'b0; mode_q <= 1'b0; idle_q <= 1'b0;
      txd_q <= '0; rxd_q <= '0; flags_q <= '0; rcnt_q <= '0;
      start_q <= 1'b0; op_q <= OP_SEND;
    end else if (soft_clr) begin
      if (soft_req) begin
        rcnt_q <= RCW'(RST_CYC);
        idle_q <= reg_wdata[0];
      end else begin
        rcnt_q <= rcnt_q - 1'b1;
      end
      ie_q <= 1'b0; ce_q <= 1'b0; go_q <= 1'b0; brk_q <= 1'b0;
      dir_q <= 1'b0; mode_q <= 1'b0;
      txd_q <= '0; rxd_q <= '0; flags_q <= '0; start_q <= 1'b0;
    end else begin
      start_q <= go_req;
      if (go_req)
        op_q <= reg_wdata[C_BRK] ? OP_BREAK : (reg_wdata[C_DIR] ? OP_RECV : OP_SEND);
      if (wr_ctrl) begin
        ie_q <= reg_wdata[C_IE];
        if (!go_q) begin
          ce_q   <= reg_wdata[C_CLK];
          go_q   <= go_req;
          brk_q  <= reg_wdata[C_BRK];
          dir_q  <= reg_wdata[C_DIR];
          mode_q <= reg_wdata[C_MODE];
        end
      end
      if (done_any) begin
        go_q  <= 1'b0;
        brk_q <= 1'b0;
      end
      if (reg_wr && (reg_word == W_TXD)) txd_q <= reg_wdata;
      if (reg_wr && (reg_word == W_CFG)) idle_q <= reg_wdata[0];
      if (done_rx) rxd_q <= rx_byte;
      flags_q <= (rd_flag ? 3'b000 : flags_q) | {done_tx, done_rx, done_to};
    end
  end

  always_comb begin
    case (reg_word)
      W_REV:   reg_rdata = REV;
      W_TXD:   reg_rdata = txd_q;
      W_RXD:   reg_rdata = rxd_q;
      W_CTRL:  reg_rdata = {1'b0, ie_q, ce_q, go_q, 1'b0, brk_q, dir_q, mode_q};
      W_FLAG:  reg_rdata = {5'b0, flags_q};
      W_CFG:   reg_rdata = {7'b0, idle_q};
      W_STAT:  reg_rdata = {7'b0, !soft_act};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign start    = start_q;
  assign start_op = op_q;
  assign busy     = go_q;
  assign tx_byte  = txd_q;
  assign irq      = ie_q && (flags_q != 3'b000);

  p_go_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_tx |=> !go_q);
  p_go_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_to |=> (!go_q && !brk_q));
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flag && !done_any && !soft_clr) |=> (flags_q == 3'b000));
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_tx && ie_q && !wr_ctrl && !soft_clr) |=> irq);
  p_ctrl_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && go_q && !done_any && !soft_clr) |=> ($stable(ce_q) && $stable(dir_q) && go_q));
  p_soft_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_req |=> (soft_act && !go_q));

endmodule

// File: rtl/sw_seq.sv
module sw_seq
  import sw_pkg::*;
#(
  parameter int unsigned BRK_LOW    = 48,
  parameter int unsigned BRK_REC    = 16,
  parameter int unsigned CELL_CYC   = 40,
  parameter int unsigned ONE_LOW    = 8,
  parameter int unsigned ZERO_LOW   = 26,
  parameter int unsigned SAMPLE_CYC = 16,
  parameter int unsigned RXWAIT_CYC = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       start,
  input  op_e        op,
  input  logic [7:0] tx_byte,
  input  logic       line_in,
  output logic       drive_low,
  output logic       done_tx,
  output logic       done_rx,
  output logic       done_to,
  output logic [7:0] rx_byte
);

  localparam int unsigned MAXC = max3(max3(BRK_LOW, BRK_REC, CELL_CYC), RXWAIT_CYC, SAMPLE_CYC);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_BLO, S_BREC, S_TLO, S_THI, S_RWAIT, S_RSAMP} st_e;

  st_e st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q;
  logic ln1_q, ln2_q, lnp_q;
  logic fall, cnt_end;

  assign fall    = lnp_q && !ln2_q;
  assign cnt_end = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ln1_q <= 1'b1; ln2_q <= 1'b1; lnp_q <= 1'b1;
    end else begin
      ln1_q <= line_in; ln2_q <= ln1_q; lnp_q <= ln2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0;
      done_tx <= 1'b0; done_rx <= 1'b0; done_to <= 1'b0;
    end else if (clr) begin
      st_q <= S_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0;
      done_tx <= 1'b0; done_rx <= 1'b0; done_to <= 1'b0;
    end else begin
      done_tx <= 1'b0; done_rx <= 1'b0; done_to <= 1'b0;
      if (!cnt_end) cnt_q <= cnt_q - 1'b1;
      case (st_q)
        S_IDLE: if (start) begin
          bit_q <= '0;
          case (op)
            OP_BREAK: begin st_q <= S_BLO; cnt_q <= CW'(BRK_LOW - 1); end
            OP_RECV:  begin st_q <= S_RWAIT; cnt_q <= CW'(RXWAIT_CYC - 1); end
            default: begin
              st_q  <= S_TLO;
              sh_q  <= tx_byte;
              cnt_q <= CW'(low_len(tx_byte[0], ONE_LOW, ZERO_LOW) - 1);
            end
          endcase
        end
        S_BLO: if (cnt_end) begin st_q <= S_BREC; cnt_q <= CW'(BRK_REC - 1); end
        S_BREC: if (cnt_end) begin st_q <= S_IDLE; done_to <= 1'b1; end
        S_TLO: if (cnt_end) begin
          st_q  <= S_THI;
          cnt_q <= CW'(CELL_CYC - low_len(sh_q[0], ONE_LOW, ZERO_LOW) - 1);
        end
        S_THI: if (cnt_end) begin
          if (bit_q == 3'd7) begin
            st_q <= S_IDLE; done_tx <= 1'b1;
          end else begin
            st_q  <= S_TLO;
            bit_q <= bit_q + 1'b1;
            sh_q  <= {1'b0, sh_q[7:1]};
            cnt_q <= CW'(low_len(sh_q[1], ONE_LOW, ZERO_LOW) - 1);
          end
        end
        S_RWAIT: begin
          if (fall) begin
            st_q <= S_RSAMP; cnt_q <= CW'(SAMPLE_CYC - 1);
          end else if (cnt_end) begin
            st_q <= S_IDLE; done_to <= 1'b1;
          end
        end
        S_RSAMP: if (cnt_end) begin
          sh_q <= {ln2_q, sh_q[7:1]};
          if (bit_q == 3'd7) begin
            st_q <= S_IDLE; done_rx <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            st_q  <= S_RWAIT; cnt_q <= CW'(RXWAIT_CYC - 1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign drive_low = (st_q == S_BLO) || (st_q == S_TLO);
  assign rx_byte   = sh_q;

  p_one_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_tx, done_rx, done_to}));
  p_brk_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_to |-> !drive_low);

endmodule

// File: rtl/sw_bus_master.sv
module sw_bus_master
  import sw_pkg::*;
#(
  parameter logic [7:0]  REV        = 8'h21,
  parameter int unsigned BRK_LOW    = 48,
  parameter int unsigned BRK_REC    = 16,
  parameter int unsigned CELL_CYC   = 40,
  parameter int unsigned ONE_LOW    = 8,
  parameter int unsigned ZERO_LOW   = 26,
  parameter int unsigned SAMPLE_CYC = 16,
  parameter int unsigned RXWAIT_CYC = 120,
  parameter int unsigned RST_CYC    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_word,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       drive_low,
  input  logic       line_in,
  output logic       irq
);

  logic       start, busy, soft_clr;
  op_e        start_op;
  logic [7:0] tx_byte, rx_byte;
  logic       done_tx, done_rx, done_to;

  sw_regs #(.REV(REV), .RST_CYC(RST_CYC)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_word(reg_word), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_tx(done_tx), .done_rx(done_rx),
    .done_to(done_to), .rx_byte(rx_byte), .start(start), .start_op(start_op),
    .busy(busy), .tx_byte(tx_byte), .soft_clr(soft_clr), .irq(irq)
  );

  sw_seq #(
    .BRK_LOW(BRK_LOW), .BRK_REC(BRK_REC), .CELL_CYC(CELL_CYC), .ONE_LOW(ONE_LOW),
    .ZERO_LOW(ZERO_LOW), .SAMPLE_CYC(SAMPLE_CYC), .RXWAIT_CYC(RXWAIT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .start(start), .op(start_op),
    .tx_byte(tx_byte), .line_in(line_in), .drive_low(drive_low), .done_tx(done_tx),
    .done_rx(done_rx), .done_to(done_to), .rx_byte(rx_byte)
  );

  p_release_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !drive_low);

endmodule

// File: tb/sw_bus_master_test.sv
module sw_bus_master_test;

  localparam int unsigned BRK_LOW = 48, BRK_REC = 16, CELL = 40, ONE_LO = 8, ZERO_LO = 26;
  localparam int unsigned RXWAIT = 120, RSTC = 4;
  localparam logic [7:0] REVV = 8'h21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_word = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic drive_low, irq, slave_low = 1'b0, line_in;
  int total = 0, bad = 0, cyc = 0;

  assign line_in = !(drive_low || slave_low);
  always #5 clk = ~clk;

  sw_bus_master uut (
    .clk(clk), .rst_n(rst_n), .reg_word(reg_word), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drive_low(drive_low),
    .line_in(line_in), .irq(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [7:0] d);
    @(negedge clk); reg_word = w; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [7:0] d);
    @(negedge clk); reg_word = w; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd3, v);
      if (!v[4]) break;
    end
  endtask

  function automatic int unsigned lo_of(input logic b);
    if (b) return ONE_LO;
    return ZERO_LO;
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd3, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    rd(3'd4, v); chk(v == 8'h00, "R1 flags", v, 0);
    rd(3'd0, v); chk(v == REVV, "R1 rev", v, REVV);
    rd(3'd6, v); chk(v[0] == 1'b1, "R1 reset done", v, 1);
    chk(!drive_low && !irq, "R1 line/irq", {drive_low, irq}, 0);
  endtask

  task automatic t_send(input logic [7:0] b);
    logic [7:0] v;
    bit ok = 1;
    int lo, hi;
    wr(3'd1, b);
    wr(3'd3, 8'h30);
    for (int i = 0; i < 8; i++) begin
      lo = 0; hi = 0;
      for (int k = 0; k < 400 && !drive_low; k++) @(negedge clk);
      while (drive_low && lo < 400) begin lo++; @(negedge clk); end
      if (lo != int'(lo_of(b[i]))) begin
        ok = 0; $display("FAIL R2 bit %0d low: act=%0d exp=%0d", i, lo, lo_of(b[i]));
      end
      if (i < 7) begin
        while (!drive_low && hi < int'(CELL) + 5) begin hi++; @(negedge clk); end
        if (lo + hi != int'(CELL)) begin
          ok = 0; $display("FAIL R2 bit %0d cell: act=%0d exp=%0d", i, lo + hi, CELL);
        end
      end
    end
    chk(ok, "R2 waveform", b, b);
    wait_idle();
    rd(3'd3, v); chk(v[4] == 1'b0, "R2 go clear", v, 8'h20);
    rd(3'd4, v); chk(v == 8'h04, "R2 tx flag", v, 4);
  endtask

  task automatic t_recv(input logic [7:0] b);
    logic [7:0] v;
    wr(3'd3, 8'h32);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      slave_low = 1'b1; repeat (lo_of(b[i])) @(negedge clk);
      slave_low = 1'b0; repeat (CELL - lo_of(b[i])) @(negedge clk);
    end
    wait_idle();
    rd(3'd4, v); chk(v == 8'h02, "R3 rx flag", v, 2);
    rd(3'd2, v); chk(v == b, "R3 rx byte", v, b);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    wr(3'd3, 8'h32);
    repeat (RXWAIT + 10) @(negedge clk);
    rd(3'd3, v); chk(v[4] == 1'b0, "R4 go clear", v, 8'h22);
    rd(3'd4, v); chk(v == 8'h01, "R4 timeout flag", v, 1);
  endtask

  task automatic t_break();
    logic [7:0] v;
    int lo = 0;
    wr(3'd3, 8'h34);
    for (int k = 0; k < 50 && !drive_low; k++) @(negedge clk);
    while (drive_low && lo < 500) begin lo++; @(negedge clk); end
    chk(lo == int'(BRK_LOW), "R5 break low", lo, BRK_LOW);
    rd(3'd3, v); chk(v[4] && v[2], "R5 busy in recovery", v, 8'h34);
    wait_idle();
    rd(3'd3, v); chk((v & 8'h14) == 8'h00, "R5 init/go clear", v, 8'h20);
    rd(3'd4, v); chk(v == 8'h01, "R5 timeout flag", v, 1);
    rd(3'd4, v); chk(v == 8'h00, "R6 read clears", v, 0);
  endtask

  task automatic t_lock_irq();
    logic [7:0] v;
    wr(3'd1, 8'hA5);
    wr(3'd3, 8'h30);
    wr(3'd3, 8'h40);
    rd(3'd3, v); chk(v == 8'h70, "R8 locked ctrl", v, 8'h70);
    chk(!irq, "R7 irq low while no flag", irq, 0);
    wait_idle();
    @(negedge clk); chk(irq, "R7 irq on flag", irq, 1);
    rd(3'd4, v); chk(v == 8'h04, "R6 flag value", v, 4);
    @(negedge clk); chk(!irq, "R7 irq after clear", irq, 0);
  endtask

  task automatic t_clk_off();
    logic [7:0] v;
    bit seen = 0;
    wr(3'd3, 8'h10);
    rd(3'd3, v); chk(v == 8'h00, "R9 go ignored", v, 0);
    for (int k = 0; k < 60; k++) begin @(negedge clk); if (drive_low) seen = 1; end
    chk(!seen, "R9 line released", seen, 0);
    rd(3'd4, v); chk(v == 8'h00, "R9 no flag", v, 0);
  endtask

  task automatic t_soft();
    logic [7:0] v;
    wr(3'd3, 8'h32);
    repeat (RXWAIT + 10) @(negedge clk);
    wr(3'd1, 8'h77);
    wr(3'd3, 8'h60);
    wr(3'd5, 8'h03);
    rd(3'd6, v); chk(v[0] == 1'b0, "R10 reset busy", v, 0);
    repeat (RSTC + 4) @(negedge clk);
    rd(3'd6, v); chk(v[0] == 1'b1, "R10 reset done", v, 1);
    rd(3'd5, v); chk(v == 8'h01, "R10 cfg stored", v, 1);
    rd(3'd3, v); chk(v == 8'h00, "R10 ctrl cleared", v, 0);
    rd(3'd1, v); chk(v == 8'h00, "R10 tx cleared", v, 0);
    rd(3'd4, v); chk(v == 8'h00, "R10 flags cleared", v, 0);
    chk(!irq, "R10 irq low", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_send(8'h5A);
    t_send(8'hF0);
    t_recv(8'h96);
    t_recv(8'h3C);
    t_timeout();
    t_break();
    t_lock_irq();
    t_clk_off();
    t_soft();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule